// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block takes 24-bit command words from a three-wire serial link and turns each one into a single write on the port of a 32-entry, 16-bit channel code memory. Words arrive most significant bit first while an active-low select line is held low. The select line and the serial clock come from outside, so every serial input passes through a two-flop synchroniser. A bit is taken on each detected rising edge of the synchronised serial clock. One select frame may carry any number of whole words back to back.

Each word holds a 16-bit code, a 5-bit channel address and two mode bits. The mode bits pick the update style (immediate or burst) and the sequencer clock (external or internal). Each mode bit is ORed with a matching external pin, so a pin held high overrides the word. While a reset sequence runs elsewhere in the chip, serial input is ignored completely. A frame that was cut into by that sequence is dropped up to its end.

A small state machine controls the block. ST_IDLE waits for select low and moves to ST_SHIFT. ST_SHIFT collects bits. When the last bit of a word arrives it moves to ST_WRITE. When select rises it returns to ST_IDLE. ST_WRITE lasts one cycle. It goes back to ST_SHIFT if select is still low, or to ST_IDLE if select has risen. From any state a high reset-sequence input forces ST_BLOCK. ST_BLOCK goes to ST_IDLE only once that input is low and select is high.

Top module: `serial_word_rx`

## Requirements
- R1: After `rst_n` is released and while select stays high, `wr_en`, `frame_active`, `mode_immediate` and `mode_ext_clk` are all 0.
- R2: Bits are taken MSB first. The first rising serial-clock edge after select falls carries bit 23. Bits 23..8 form the code, bits 7..3 the address (0 to 31), bit 2 the immediate bit, bit 1 the external-clock bit and bit 0 a fill bit. Each word writes its code to `wr_data` and its address to `wr_addr`.
- R3: Every complete word raises `wr_en` for exactly one clock cycle. This is the cycle after the third `clk` edge that follows the 24th rising edge on `sclk_in`.
- R4: Several words sent inside one select frame each produce their own write, in the order they were sent.
- R5: A partial word that is pending when select rises is discarded without a write. The next frame starts again at bit 23.
- R6: The saved mode bits take the values from a word one cycle after that word's strobe. `mode_immediate` is the saved immediate bit OR the synchronised `imm_pin`. `mode_ext_clk` is the saved external-clock bit OR the synchronised `eclk_sel_pin`.
- R7: The external-clock choice has to be repeated in every word. A word whose bit 1 is 0 drives `mode_ext_clk` back to 0 when `eclk_sel_pin` is low.
- R8: `frame_active` is the inverse of `csn_in`, delayed by two clock cycles.
- R9: While `seq_reset` is high, no bit is taken, no write occurs and the saved mode bits stay unchanged. Bits of a frame still open when `seq_reset` falls are ignored until select has gone high.
- R10: The fill bit has no effect on the written address, the written code or the mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_reset | input | 1 | High while a reset sequence runs (already synchronous) |
| csn_in | input | 1 | Active-low frame select, asynchronous |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdi_in | input | 1 | Serial data, asynchronous |
| imm_pin | input | 1 | External immediate-mode request |
| eclk_sel_pin | input | 1 | External clock-select request |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 5 | Memory write address |
| wr_data | output | 16 | Memory write code |
| frame_active | output | 1 | Synchronised inverse of select |
| mode_immediate | output | 1 | Immediate update selected |
| mode_ext_clk | output | 1 | External sequencer clock selected |

## Verification
The assertions assume three things about the serial side. The serial clock stays at each level for several system clocks. Select changes only while the serial clock is low, with a few system clocks of margin on both sides of the first and last edge. `seq_reset` is a synchronous level that never rises in the same cycle as a strobe. The stimulus keeps to these limits: it holds each serial-clock phase for four cycles, waits six cycles after select falls and four after the last edge, and changes `seq_reset` only between bits. The frame-follower assertion also assumes a two-stage synchroniser and compares select with a two-cycle delay.

// File: rtl/swr_pkg.sv
package swr_pkg;

    // Control and fill bits that trail the address in every word
    localparam int CTRL_W = 2;
    localparam int FILL_W = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WRITE = 2'd2,
        ST_BLOCK = 2'd3
    } rx_state_t;

    function automatic int word_width(input int data_w, input int addr_w);
        return data_w + addr_w + CTRL_W + FILL_W;
    endfunction

endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = STAGES * WIDTH;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
        end
    end

    assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/swr_edge.sv
module swr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_prev <= 1'b0;
        end else begin
            level_prev <= level;
        end
    end

    assign rise = level & ~level_prev;

endmodule

// File: rtl/swr_shifter.sv
module swr_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              word_done,
    output logic [WORD_W-2:0] word_q
);
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int PAY_W   = WORD_W - 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PAY_W-1:0] shreg_q;

    assign word_done = shift_en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            cnt_q <= word_done ? '0 : cnt_q + 1'b1;
        end
    end

    // The last bit of a word is the fill bit: it is dropped, and the
    // payload already held in shreg_q is moved to the hold register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            word_q  <= '0;
        end else if (shift_en) begin
            if (word_done) begin
                word_q <= shreg_q;
            end else begin
                shreg_q <= {shreg_q[PAY_W-2:0], bit_in};
            end
        end
    end

endmodule

// File: rtl/swr_fsm.sv
module swr_fsm
    import swr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      csn_s,
    input  logic      seq_reset,
    input  logic      word_done,
    input  logic      c1_in,
    input  logic      c0_in,
    output rx_state_t state_q,
    output logic      wr_en,
    output logic      c1_q,
    output logic      c0_q
);
    rx_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!csn_s) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (word_done)  state_d = ST_WRITE;
                else if (csn_s) state_d = ST_IDLE;
            end
            ST_WRITE: state_d = csn_s ? ST_IDLE : ST_SHIFT;
            ST_BLOCK: if (csn_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (seq_reset) state_d = ST_BLOCK;
    end

    always_comb begin
        wr_en = (state_q == ST_WRITE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_q <= 1'b0;
            c0_q <= 1'b0;
        end else if (state_q == ST_WRITE) begin
            c1_q <= c1_in;
            c0_q <= c0_in;
        end
    end

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
    import swr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_reset,
    input  logic              csn_in,
    input  logic              sclk_in,
    input  logic              sdi_in,
    input  logic              imm_pin,
    input  logic              eclk_sel_pin,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_active,
    output logic              mode_immediate,
    output logic              mode_ext_clk
);
    localparam int WORD_W = word_width(DATA_W, ADDR_W);
    localparam int PAY_W  = WORD_W - FILL_W;
    localparam int NSYNC  = 5;

    logic [NSYNC-1:0] raw_in, sync_out;
    logic csn_s, sclk_s, sdi_s, imm_s, ecs_s;
    logic sclk_rise, shift_en, clear, word_done;
    logic [PAY_W-1:0] word_q;
    rx_state_t state_q;
    logic c1_q, c0_q;

    assign raw_in = {eclk_sel_pin, imm_pin, sdi_in, sclk_in, csn_in};

    swr_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b00001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_out)
    );

    assign {ecs_s, imm_s, sdi_s, sclk_s, csn_s} = sync_out;

    swr_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(sclk_s),
        .rise (sclk_rise)
    );

    assign shift_en = sclk_rise && !csn_s && !seq_reset && (state_q != ST_BLOCK);
    assign clear    = csn_s || seq_reset || (state_q == ST_BLOCK);

    swr_shifter #(
        .WORD_W(WORD_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .bit_in   (sdi_s),
        .word_done(word_done),
        .word_q   (word_q)
    );

    swr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_s    (csn_s),
        .seq_reset(seq_reset),
        .word_done(word_done),
        .c1_in    (word_q[1]),
        .c0_in    (word_q[0]),
        .state_q  (state_q),
        .wr_en    (wr_en),
        .c1_q     (c1_q),
        .c0_q     (c0_q)
    );

    assign wr_data        = word_q[PAY_W-1 -: DATA_W];
    assign wr_addr        = word_q[CTRL_W +: ADDR_W];
    assign frame_active   = ~csn_s;
    assign mode_immediate = c1_q | imm_s;
    assign mode_ext_clk   = c0_q | ecs_s;

endmodule

// File: rtl/swr_checker.sv
module swr_checker (
    input logic clk,
    input logic rst_n,
    input logic seq_reset,
    input logic csn_in,
    input logic wr_en,
    input logic frame_active,
    input logic c1_saved,
    input logic c0_saved
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 1'b1;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3

    AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(frame_active)); // R4

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(c1_saved) && $stable(c0_saved))); // R6

    AST_FRAME_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (frame_active == !$past(csn_in, 2))); // R8

    AST_SILENT_IN_RESET_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_reset) |-> !wr_en); // R9

endmodule

bind serial_word_rx swr_checker u_swr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_reset   (seq_reset),
    .csn_in      (csn_in),
    .wr_en       (wr_en),
    .frame_active(frame_active),
    .c1_saved    (c1_q),
    .c0_saved    (c0_q)
);

// File: tb/test_serial_word_rx.sv
`timescale 1ns/1ps
module test_serial_word_rx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_reset = 1'b0;
    logic csn_in = 1'b1;
    logic sclk_in = 1'b0;
    logic sdi_in = 1'b0;
    logic imm_pin = 1'b0;
    logic eclk_sel_pin = 1'b0;
    logic wr_en;
    logic [4:0] wr_addr;
    logic [15:0] wr_data;
    logic frame_active, mode_immediate, mode_ext_clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_writes = 0;
    bit started = 0;
    string cur_tag = "R1";
    logic [15:0] mem_seen [32];

    always #2.5 clk = ~clk;

    serial_word_rx i_serial_word_rx (
        .clk(clk), .rst_n(rst_n), .seq_reset(seq_reset),
        .csn_in(csn_in), .sclk_in(sclk_in), .sdi_in(sdi_in),
        .imm_pin(imm_pin), .eclk_sel_pin(eclk_sel_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_active(frame_active), .mode_immediate(mode_immediate),
        .mode_ext_clk(mode_ext_clk)
    );

    // Behavioural reference: input histories, bit counting and a word log
    bit cs_h[4], sk_h[4], sd_h[4], im_h[4], ec_h[4];
    int m_cnt;
    bit [23:0] m_word, m_wword;
    bit m_blk, m_wr, m_c1, m_c0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                cs_h[i] = 1; sk_h[i] = 0; sd_h[i] = 0; im_h[i] = 0; ec_h[i] = 0;
            end
            m_cnt = 0; m_word = '0; m_wword = '0;
            m_blk = 0; m_wr = 0; m_c1 = 0; m_c0 = 0;
        end else begin
            bit rise, shift, nwr;
            if (m_wr) begin
                m_c1 = m_wword[2];
                m_c0 = m_wword[1];
            end
            for (int i = 3; i > 0; i--) begin
                cs_h[i] = cs_h[i-1]; sk_h[i] = sk_h[i-1]; sd_h[i] = sd_h[i-1];
                im_h[i] = im_h[i-1]; ec_h[i] = ec_h[i-1];
            end
            cs_h[0] = csn_in; sk_h[0] = sclk_in; sd_h[0] = sdi_in;
            im_h[0] = imm_pin; ec_h[0] = eclk_sel_pin;
            rise  = sk_h[2] && !sk_h[3];
            shift = !m_blk && !seq_reset && !cs_h[2] && rise;
            nwr   = 0;
            if (cs_h[2] || seq_reset || m_blk) begin
                m_cnt = 0;
            end else if (shift) begin
                m_word = {m_word[22:0], sd_h[2]};
                m_cnt++;
                if (m_cnt == 24) begin
                    nwr = 1;
                    m_wword = m_word;
                    m_cnt = 0;
                end
            end
            m_blk = seq_reset ? 1'b1 : (m_blk && !cs_h[2]);
            m_wr  = nwr;
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && started) begin
            cmp("wr_en", 32'(wr_en), 32'(m_wr));
            if (m_wr) begin
                cmp("wr_addr", 32'(wr_addr), 32'(m_wword[7:3]));
                cmp("wr_data", 32'(wr_data), 32'(m_wword[23:8]));
            end
            cmp("frame_active", 32'(frame_active), 32'(!cs_h[1]));
            cmp("mode_immediate", 32'(mode_immediate), 32'(m_c1 | im_h[1]));
            cmp("mode_ext_clk", 32'(mode_ext_clk), 32'(m_c0 | ec_h[1]));
            if (wr_en === 1'b1) begin
                mem_seen[wr_addr] = wr_data;
                n_writes++;
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdi_in  = b;
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    task automatic cs_low;
        @(negedge clk);
        csn_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_high;
        repeat (4) @(negedge clk);
        csn_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] d, input logic [4:0] a,
                             input logic c1, input logic c0, input logic fill);
        logic [23:0] w;
        w = {d, a, c1, c0, fill};
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic send_bits(input logic [23:0] w, input int n);
        for (int i = 23; i > 23 - n; i--) send_bit(w[i]);
    endtask

    initial begin
        int w0;
        for (int i = 0; i < 32; i++) mem_seen[i] = 16'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        repeat (4) @(negedge clk);

        cur_tag = "R1";
        cmp("reset wr_en", 32'(wr_en), 0);
        cmp("reset frame_active", 32'(frame_active), 0);
        cmp("reset modes", 32'({mode_immediate, mode_ext_clk}), 0);

        cur_tag = "R2";
        cs_low();
        cur_tag = "R8";
        cmp("frame_active in frame", 32'(frame_active), 1);
        cur_tag = "R2";
        send_word(16'hA5C3, 5'd19, 1'b0, 1'b0, 1'b0);
        cs_high();
        cmp("code at 19", 32'(mem_seen[19]), 32'h A5C3);
        cur_tag = "R3";
        cmp("one strobe", 32'(n_writes), 1);

        cur_tag = "R4";
        cs_low();
        send_word(16'h0001, 5'd0, 1'b0, 1'b0, 1'b0);
        send_word(16'hFFFF, 5'd31, 1'b0, 1'b0, 1'b0);
        send_word(16'h4F2C, 5'd7, 1'b0, 1'b0, 1'b0);
        cs_high();
        cmp("three strobes", 32'(n_writes), 4);
        cmp("code at 0", 32'(mem_seen[0]), 32'h0001);
        cmp("code at 31", 32'(mem_seen[31]), 32'hFFFF);
        cmp("code at 7", 32'(mem_seen[7]), 32'h4F2C);

        cur_tag = "R6";
        imm_pin = 1'b1;
        repeat (4) @(negedge clk);
        cmp("pin forces immediate", 32'(mode_immediate), 1);
        imm_pin = 1'b0;
        cs_low();
        send_word(16'h1234, 5'd3, 1'b1, 1'b0, 1'b0);
        cs_high();
        cmp("word sets immediate", 32'(mode_immediate), 1);
        cs_low();
        send_word(16'h2345, 5'd4, 1'b0, 1'b0, 1'b0);
        cs_high();
        cmp("word clears immediate", 32'(mode_immediate), 0);

        cur_tag = "R7";
        cs_low();
        send_word(16'h3456, 5'd5, 1'b0, 1'b1, 1'b0);
        cmp("ext clock set", 32'(mode_ext_clk), 1);
        send_word(16'h4567, 5'd6, 1'b0, 1'b0, 1'b0);
        cs_high();
        cmp("ext clock not repeated", 32'(mode_ext_clk), 0);

        cur_tag = "R5";
        w0 = n_writes;
        cs_low();
        send_bits(24'hFFFFFF, 10);
        cs_high();
        cmp("partial word no strobe", 32'(n_writes), 32'(w0));
        cs_low();
        send_word(16'h0F0F, 5'd9, 1'b0, 1'b0, 1'b0);
        cs_high();
        cmp("fresh word code", 32'(mem_seen[9]), 32'h0F0F);
        cmp("fresh word strobe", 32'(n_writes), 32'(w0 + 1));

        cur_tag = "R9";
        w0 = n_writes;
        @(negedge clk);
        seq_reset = 1'b1;
        cs_low();
        send_word(16'hDEAD, 5'd12, 1'b1, 1'b1, 1'b0);
        cs_high();
        seq_reset = 1'b0;
        repeat (4) @(negedge clk);
        cmp("no write in reset seq", 32'(n_writes), 32'(w0));
        cmp("modes kept", 32'({mode_immediate, mode_ext_clk}), 0);
        cs_low();
        send_bits(24'hBEEF64, 8);
        seq_reset = 1'b1;
        send_bits(24'hEF6400, 4);
        seq_reset = 1'b0;
        send_bits(24'hF64000, 12);
        cs_high();
        cmp("cut frame dropped", 32'(n_writes), 32'(w0));
        cmp("code at 12 untouched", 32'(mem_seen[12]), 0);
        cs_low();
        send_word(16'h7777, 5'd12, 1'b0, 1'b0, 1'b0);
        cs_high();
        cmp("frame after reset seq", 32'(mem_seen[12]), 32'h7777);

        cur_tag = "R10";
        cs_low();
        send_word(16'h5A5A, 5'd21, 1'b0, 1'b0, 1'b1);
        cs_high();
        cmp("fill ignored code", 32'(mem_seen[21]), 32'h5A5A);
        cmp("fill ignored modes", 32'({mode_immediate, mode_ext_clk}), 0);

        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule